// File: doc/BRIEF.md
# Masked Pipelined Vector Adder

This block adds two vectors of eight 32-bit elements. Every operand arrives as two Boolean shares, and every result leaves as two Boolean shares. The plain value of any operand or result is the XOR of its two shares. The sum of each element is taken modulo 2^32. Inside the block, no signal ever combines the two shares of the same secret.

The core of the block is an element adder with a six-stage pipeline. Its first stage forms per-bit generate and propagate terms. Generate is produced by a masked AND gadget, and propagate is the share-wise XOR of the operands. The next five stages form a Sklansky parallel-prefix carry tree. Each AND in that tree is a domain-oriented masked gadget that registers its cross-domain terms together with fresh random bits. The final sum share is the propagate share XOR the shifted group-generate share of the same domain.

A lane feeder accepts one start request. It sends lane 0 straight from the input ports in the start cycle. It then sends lanes 1 to 7 from a shift register on the next seven cycles. A collector writes each result lane as it leaves the pipeline. The randomness input carries 32 fresh bits for each of the six stages in every cycle, 192 bits in total.

Top module: `mskadd_vec_top`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are low and both result share vectors are zero.
- R2: For every lane k (bits 32k+31 down to 32k), the XOR of `sum_sh0` and `sum_sh1` equals (a_sh0^a_sh1)+(b_sh0^b_sh1) modulo 2^32. This holds for any value on `rnd`.
- R3: When `rnd` is held at zero and both share-1 operand vectors are zero, `sum_sh1` is zero and `sum_sh0` is the plain sum.
- R4: Each element leaves the pipeline exactly six cycles after it enters. Lanes enter in ascending order on consecutive cycles, and lane 0 enters in the cycle in which start is accepted.
- R5: `done` is high for exactly one cycle. It rises on the 13th rising edge after the edge that samples start. `busy` is high from the edge that samples start until that edge, and it is low while `done` is high.
- R6: A start request that arrives while `busy` is high is ignored, even when the operand ports have changed. Results and timing are those of the run already under way.
- R7: A start request in the cycle in which `done` is high is accepted. The new run has the same timing and gives correct results.
- R8: Between runs, both result share vectors keep the last result.
- R9: Carries travel across the full 32 bits of a lane and wrap at 2^32. A carry never enters the neighbouring lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to add the vectors now on the operand ports |
| a_sh0 | input | 256 | Operand A, share 0, lane k at bits 32k+31:32k |
| a_sh1 | input | 256 | Operand A, share 1 |
| b_sh0 | input | 256 | Operand B, share 0 |
| b_sh1 | input | 256 | Operand B, share 1 |
| rnd | input | 192 | Fresh random bits, 32 per pipeline stage, each cycle |
| busy | output | 1 | A vector run is in progress |
| done | output | 1 | One-cycle pulse when all eight result lanes are written |
| sum_sh0 | output | 256 | Result, share 0 |
| sum_sh1 | output | 256 | Result, share 1 |

## Verification
Two functions can fall in the same cycle. One is the capture of the last result lane together with the `done` pulse. The other is the acceptance of a new start request, which puts the next run's lane 0 into the pipeline in that same cycle. The bench provokes this by asserting start again in the cycle in which `done` is high. It then checks that the first run's result is intact at that moment and that the second run finishes on the same 13-edge schedule with its own correct sums. A start pulse with changed operand ports is also injected in the middle of a run, to show that the lanes already latched are unaffected.

// File: rtl/mskadd_pkg.sv
`timescale 1ns/1ps
package mskadd_pkg;
    localparam int unsigned EW       = 32;
    localparam int unsigned LANES    = 8;
    localparam int unsigned VW       = EW * LANES;
    localparam int unsigned LVLS     = $clog2(EW);
    localparam int unsigned STAGES   = LVLS + 1;
    localparam int unsigned RND_W    = STAGES * EW;
    localparam int unsigned LANE_IW  = (LANES > 1) ? $clog2(LANES) : 1;

    typedef logic [EW-1:0] word_t;

    typedef struct packed {
        word_t sh0;
        word_t sh1;
    } shword_t;

    typedef struct packed {
        logic    vld;
        shword_t g;     // group generate, shared
        shword_t p;     // group propagate, shared
        shword_t prop;  // per-bit propagate kept for the final sum
    } pfx_t;

    // Bit i merges at level lvl when bit (lvl-1) of i is set.
    function automatic bit pfx_upper(input int unsigned i, input int unsigned lvl);
        return ((i >> (lvl - 1)) & 1) == 1;
    endfunction

    // Highest bit of the lower half of the block that holds bit i.
    function automatic int unsigned pfx_src(input int unsigned i, input int unsigned lvl);
        return ((i >> lvl) << lvl) + (1 << (lvl - 1)) - 1;
    endfunction

    // Compact index of a merging bit, used to pick its random bits.
    function automatic int unsigned pfx_slot(input int unsigned i, input int unsigned lvl);
        return ((i >> lvl) << (lvl - 1)) + (i & ((1 << (lvl - 1)) - 1));
    endfunction
endpackage

// File: rtl/mskadd_and_gadget.sv
`timescale 1ns/1ps
module mskadd_and_gadget #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] y0,
    input  logic [W-1:0] y1,
    input  logic [W-1:0] r,
    output logic [W-1:0] z0,
    output logic [W-1:0] z1
);
    logic [W-1:0] in0_q, cr0_q, in1_q, cr1_q;

    // Cross-domain products are blinded by r and registered before any XOR.
    always_ff @(posedge clk) begin
        in0_q <= x0 & y0;
        cr0_q <= (x0 & y1) ^ r;
        in1_q <= x1 & y1;
        cr1_q <= (x1 & y0) ^ r;
    end

    assign z0 = in0_q ^ cr0_q;
    assign z1 = in1_q ^ cr1_q;
endmodule

// File: rtl/mskadd_gp_stage.sv
`timescale 1ns/1ps
module mskadd_gp_stage
    import mskadd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_vld,
    input  shword_t a,
    input  shword_t b,
    input  word_t   rnd,
    output pfx_t    q
);
    word_t g0, g1, p0_q, p1_q;
    logic  vld_q;

    mskadd_and_gadget #(.W(EW)) u_gen (
        .clk(clk), .x0(a.sh0), .x1(a.sh1), .y0(b.sh0), .y1(b.sh1),
        .r(rnd), .z0(g0), .z1(g1)
    );

    always_ff @(posedge clk) begin
        p0_q <= a.sh0 ^ b.sh0;
        p1_q <= a.sh1 ^ b.sh1;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_vld;
    end

    always_comb begin
        q.vld      = vld_q;
        q.g.sh0    = g0;
        q.g.sh1    = g1;
        q.p.sh0    = p0_q;
        q.p.sh1    = p1_q;
        q.prop.sh0 = p0_q;
        q.prop.sh1 = p1_q;
    end
endmodule

// File: rtl/mskadd_pfx_level.sv
`timescale 1ns/1ps
module mskadd_pfx_level
    import mskadd_pkg::*;
#(
    parameter int unsigned LVL = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  pfx_t  d,
    input  word_t rnd,
    output pfx_t  q
);
    word_t g0_n, g1_n, p0_n, p1_n, pr0_q, pr1_q;
    logic  vld_q;

    for (genvar i = 0; i < EW; i++) begin : g_bit
        if (pfx_upper(i, LVL)) begin : g_merge
            localparam int unsigned SRC  = pfx_src(i, LVL);
            localparam int unsigned SLOT = pfx_slot(i, LVL);
            logic gh0, gh1, zg0, zg1, zp0, zp1;

            always_ff @(posedge clk) begin
                gh0 <= d.g.sh0[i];
                gh1 <= d.g.sh1[i];
            end

            mskadd_and_gadget #(.W(1)) u_gand (
                .clk(clk), .x0(d.p.sh0[i]), .x1(d.p.sh1[i]),
                .y0(d.g.sh0[SRC]), .y1(d.g.sh1[SRC]),
                .r(rnd[2*SLOT]), .z0(zg0), .z1(zg1)
            );
            mskadd_and_gadget #(.W(1)) u_pand (
                .clk(clk), .x0(d.p.sh0[i]), .x1(d.p.sh1[i]),
                .y0(d.p.sh0[SRC]), .y1(d.p.sh1[SRC]),
                .r(rnd[2*SLOT+1]), .z0(zp0), .z1(zp1)
            );

            // Generate and propagate of a group never overlap, so OR is XOR.
            assign g0_n[i] = gh0 ^ zg0;
            assign g1_n[i] = gh1 ^ zg1;
            assign p0_n[i] = zp0;
            assign p1_n[i] = zp1;
        end else begin : g_pass
            logic gq0, gq1, pq0, pq1;
            always_ff @(posedge clk) begin
                gq0 <= d.g.sh0[i];
                gq1 <= d.g.sh1[i];
                pq0 <= d.p.sh0[i];
                pq1 <= d.p.sh1[i];
            end
            assign g0_n[i] = gq0;
            assign g1_n[i] = gq1;
            assign p0_n[i] = pq0;
            assign p1_n[i] = pq1;
        end
    end

    always_ff @(posedge clk) begin
        pr0_q <= d.prop.sh0;
        pr1_q <= d.prop.sh1;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= d.vld;
    end

    always_comb begin
        q.vld      = vld_q;
        q.g.sh0    = g0_n;
        q.g.sh1    = g1_n;
        q.p.sh0    = p0_n;
        q.p.sh1    = p1_n;
        q.prop.sh0 = pr0_q;
        q.prop.sh1 = pr1_q;
    end
endmodule

// File: rtl/mskadd_pipe.sv
`timescale 1ns/1ps
module mskadd_pipe
    import mskadd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  shword_t          a,
    input  shword_t          b,
    input  logic [RND_W-1:0] rnd,
    output logic             out_vld,
    output shword_t          sum
);
    pfx_t st [STAGES];

    mskadd_gp_stage u_gp (
        .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b),
        .rnd(rnd[EW-1:0]), .q(st[0])
    );

    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        mskadd_pfx_level #(.LVL(l)) u_lvl (
            .clk(clk), .rst(rst), .d(st[l-1]),
            .rnd(rnd[l*EW +: EW]), .q(st[l])
        );
    end

    // Carry into bit i is the group generate of bits i-1..0, same share.
    assign out_vld = st[LVLS].vld;
    assign sum.sh0 = st[LVLS].prop.sh0 ^ {st[LVLS].g.sh0[EW-2:0], 1'b0};
    assign sum.sh1 = st[LVLS].prop.sh1 ^ {st[LVLS].g.sh1[EW-2:0], 1'b0};

    // Terms the last level forms but the sum does not need, kept per share.
    logic [EW:0] unused_tail_sh0, unused_tail_sh1;
    assign unused_tail_sh0 = {st[LVLS].p.sh0, st[LVLS].g.sh0[EW-1]};
    assign unused_tail_sh1 = {st[LVLS].p.sh1, st[LVLS].g.sh1[EW-1]};
endmodule

// File: rtl/mskadd_feeder.sv
`timescale 1ns/1ps
module mskadd_feeder
    import mskadd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          finish,
    input  logic [VW-1:0] a0,
    input  logic [VW-1:0] a1,
    input  logic [VW-1:0] b0,
    input  logic [VW-1:0] b1,
    output logic          busy,
    output logic          elem_vld,
    output shword_t       ea,
    output shword_t       eb
);
    localparam int unsigned HW = VW - EW;

    logic [HW-1:0]      la0, la1, lb0, lb1;
    logic [LANE_IW-1:0] cnt_q;
    logic               iss_q, busy_q, launch;

    assign launch   = start & ~busy_q;
    assign busy     = busy_q;
    assign elem_vld = launch | iss_q;

    // Lane 0 bypasses the holding registers; later lanes come from their low word.
    always_comb begin
        if (launch) begin
            ea.sh0 = a0[EW-1:0];
            ea.sh1 = a1[EW-1:0];
            eb.sh0 = b0[EW-1:0];
            eb.sh1 = b1[EW-1:0];
        end else begin
            ea.sh0 = la0[EW-1:0];
            ea.sh1 = la1[EW-1:0];
            eb.sh0 = lb0[EW-1:0];
            eb.sh1 = lb1[EW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (launch) begin
            la0 <= a0[VW-1:EW];
            la1 <= a1[VW-1:EW];
            lb0 <= b0[VW-1:EW];
            lb1 <= b1[VW-1:EW];
        end else if (iss_q) begin
            la0 <= la0 >> EW;
            la1 <= la1 >> EW;
            lb0 <= lb0 >> EW;
            lb1 <= lb1 >> EW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            iss_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (launch)      busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;
            if (launch) begin
                iss_q <= (LANES > 1);
                cnt_q <= LANE_IW'(1);
            end else if (iss_q) begin
                if (cnt_q == LANE_IW'(LANES - 1)) iss_q <= 1'b0;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mskadd_collect.sv
`timescale 1ns/1ps
module mskadd_collect
    import mskadd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  shword_t       sum,
    output logic          last,
    output logic [VW-1:0] s0,
    output logic [VW-1:0] s1
);
    logic [LANE_IW-1:0] cnt_q;
    logic [VW-1:0]      s0_q, s1_q;

    assign last = in_vld & (cnt_q == LANE_IW'(LANES - 1));
    assign s0   = s0_q;
    assign s1   = s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            s0_q  <= '0;
            s1_q  <= '0;
        end else if (in_vld) begin
            s0_q[cnt_q*EW +: EW] <= sum.sh0;
            s1_q[cnt_q*EW +: EW] <= sum.sh1;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mskadd_vec_top.sv
`timescale 1ns/1ps
module mskadd_vec_top
    import mskadd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VW-1:0]    a_sh0,
    input  logic [VW-1:0]    a_sh1,
    input  logic [VW-1:0]    b_sh0,
    input  logic [VW-1:0]    b_sh1,
    input  logic [RND_W-1:0] rnd,
    output logic             busy,
    output logic             done,
    output logic [VW-1:0]    sum_sh0,
    output logic [VW-1:0]    sum_sh1
);
    logic    elem_in_vld, elem_out_vld, fin, done_q;
    shword_t ea, eb, esum;

    mskadd_feeder u_feed (
        .clk(clk), .rst(rst), .start(start), .finish(fin),
        .a0(a_sh0), .a1(a_sh1), .b0(b_sh0), .b1(b_sh1),
        .busy(busy), .elem_vld(elem_in_vld), .ea(ea), .eb(eb)
    );

    mskadd_pipe u_pipe (
        .clk(clk), .rst(rst), .in_vld(elem_in_vld), .a(ea), .b(eb),
        .rnd(rnd), .out_vld(elem_out_vld), .sum(esum)
    );

    mskadd_collect u_coll (
        .clk(clk), .rst(rst), .in_vld(elem_out_vld), .sum(esum),
        .last(fin), .s0(sum_sh0), .s1(sum_sh1)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= fin;
    end
    assign done = done_q;
endmodule

// File: rtl/mskadd_chk.sv
`timescale 1ns/1ps
module mskadd_chk
    import mskadd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          elem_in_vld,
    input logic          elem_out_vld,
    input logic [VW-1:0] sum_sh0,
    input logic [VW-1:0] sum_sh1
);
    logic [2:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)              cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 1'b1;
    end

    AST_LAT_SIX: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd6) |-> (elem_out_vld == $past(elem_in_vld, 6)))
        else $error("element latency is not six cycles"); // R4

    AST_ENTRY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        elem_in_vld |-> (busy || start))
        else $error("element entered outside a run"); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle"); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("busy high with done"); // R5

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start))
        else $error("run began without start"); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc != 3'd0 && !$past(elem_out_vld)) |-> ($stable(sum_sh0) && $stable(sum_sh1)))
        else $error("result changed without a lane"); // R8
endmodule

bind mskadd_vec_top mskadd_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .elem_in_vld(elem_in_vld), .elem_out_vld(elem_out_vld),
    .sum_sh0(sum_sh0), .sum_sh1(sum_sh1)
);

// File: tb/mskadd_vec_top_test.sv
`timescale 1ns/1ps
module mskadd_vec_top_test;
    import mskadd_pkg::*;

    logic             clk, rst, start, busy, done, rnd_zero;
    logic [VW-1:0]    a_sh0, a_sh1, b_sh0, b_sh1, sum_sh0, sum_sh1;
    logic [RND_W-1:0] rnd;
    int               n_tests, n_fail;

    mskadd_vec_top uut (
        .clk(clk), .rst(rst), .start(start),
        .a_sh0(a_sh0), .a_sh1(a_sh1), .b_sh0(b_sh0), .b_sh1(b_sh1),
        .rnd(rnd), .busy(busy), .done(done),
        .sum_sh0(sum_sh0), .sum_sh1(sum_sh1)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    // Fresh masking randomness every cycle unless forced to zero.
    initial begin
        rnd = '0;
        forever begin
            @(negedge clk);
            if (rnd_zero) rnd <= '0;
            else for (int k = 0; k < RND_W / 32; k++) rnd[k*32 +: 32] <= $urandom;
        end
    end

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] ref_sum(input logic [VW-1:0] x0, x1, y0, y1);
        logic [VW-1:0] r;
        for (int k = 0; k < LANES; k++)
            r[k*EW +: EW] = (x0[k*EW +: EW] ^ x1[k*EW +: EW]) + (y0[k*EW +: EW] ^ y1[k*EW +: EW]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a negedge; returns at the negedge where done must be high.
    task automatic run_vec(input logic [VW-1:0] x0, x1, y0, y1, input bit poke, input string tag);
        int bad_at;
        logic [VW-1:0] exp;
        bad_at = 0;
        exp = ref_sum(x0, x1, y0, y1);
        a_sh0 <= x0; a_sh1 <= x1; b_sh0 <= y0; b_sh1 <= y1;
        start <= 1'b1;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            if (n == 1) start <= 1'b0;
            if (poke && n == 3) begin
                start <= 1'b1;
                a_sh0 <= ~x0;
                b_sh1 <= rand_vec();
            end
            if (poke && n == 4) start <= 1'b0;
            if (n < 14 && !(busy == 1'b1 && done == 1'b0) && bad_at == 0) bad_at = n;
        end
        if (!(done == 1'b1 && busy == 1'b0) && bad_at == 0) bad_at = 14;
        chk(bad_at == 0, "R4 R5 lane schedule and done/busy timing", VW'(bad_at), '0);
        chk((sum_sh0 ^ sum_sh1) == exp, tag, sum_sh0 ^ sum_sh1, exp);
    endtask

    task automatic pulse_end();
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R5 done is a single-cycle pulse", VW'({busy, done}), '0);
    endtask

    initial begin
        logic [VW-1:0] va, vb, ma, mb, hold0, hold1;
        n_tests = 0; n_fail = 0;
        void'($urandom(32'd20251));
        rst = 1'b1; start = 1'b0; rnd_zero = 1'b0;
        a_sh0 = '0; a_sh1 = '0; b_sh0 = '0; b_sh1 = '0;
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset controls", VW'({busy, done}), '0);
        chk(sum_sh0 == '0 && sum_sh1 == '0, "R1 reset results", sum_sh0 | sum_sh1, '0);

        // R9: carry corners per lane, lane 0 lowest
        va = {32'hFFFFFFFE, 32'h12345678, 32'h0000FFFF, 32'hFFFFFFFF,
              32'h00000000, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF};
        vb = {32'h00000001, 32'hEDCBA988, 32'h00000001, 32'hFFFFFFFF,
              32'h00000000, 32'h80000000, 32'h00000001, 32'h00000001};
        ma = rand_vec(); mb = rand_vec();
        run_vec(ma, va ^ ma, mb, vb ^ mb, 1'b0, "R9 carry wrap and lane isolation");
        chk((sum_sh0 ^ sum_sh1) == ref_sum(va, '0, vb, '0), "R2 corner recombination",
            sum_sh0 ^ sum_sh1, ref_sum(va, '0, vb, '0));
        pulse_end();

        // R3: zero randomness and zero share-1 inputs
        rnd_zero = 1'b1;
        @(negedge clk);
        @(negedge clk);
        va = rand_vec(); vb = rand_vec();
        run_vec(va, '0, vb, '0, 1'b0, "R2 zero-randomness sum");
        chk(sum_sh1 == '0, "R3 share 1 stays zero", sum_sh1, '0);
        chk(sum_sh0 == ref_sum(va, '0, vb, '0), "R3 share 0 is plain sum", sum_sh0, ref_sum(va, '0, vb, '0));
        rnd_zero = 1'b0;
        pulse_end();

        // R8: results hold while idle and ports wander
        hold0 = sum_sh0; hold1 = sum_sh1;
        for (int i = 0; i < 6; i++) begin
            a_sh0 <= rand_vec(); b_sh1 <= rand_vec();
            @(negedge clk);
        end
        chk(sum_sh0 == hold0, "R8 share 0 held", sum_sh0, hold0);
        chk(sum_sh1 == hold1, "R8 share 1 held", sum_sh1, hold1);

        // R6: start with changed ports during a run is ignored
        va = rand_vec(); vb = rand_vec(); ma = rand_vec(); mb = rand_vec();
        run_vec(ma, va ^ ma, mb, vb ^ mb, 1'b1, "R6 start while busy ignored");
        pulse_end();

        // R7: back-to-back runs, new start in the done cycle
        va = rand_vec(); vb = rand_vec(); ma = rand_vec(); mb = rand_vec();
        run_vec(ma, va ^ ma, mb, vb ^ mb, 1'b0, "R7 first of chained runs");
        va = rand_vec(); vb = rand_vec(); ma = rand_vec(); mb = rand_vec();
        run_vec(ma, va ^ ma, mb, vb ^ mb, 1'b0, "R7 second of chained runs");
        pulse_end();

        // R2: random masked vectors with random idle gaps
        for (int t = 0; t < 10; t++) begin
            run_vec(rand_vec(), rand_vec(), rand_vec(), rand_vec(), 1'b0, "R2 random masked sum");
            pulse_end();
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule